// File: doc/BRIEF.md
# Dual-Channel Sample Input Formatter

This block sits between a narrow parallel sample bus and the datapath of a two-channel DAC. Each accepted bus beat carries one slice of a 16-bit sample. The block assembles the slices into whole words and pairs two words into one I/Q sample. It puts that pair on its outputs for one cycle, always in twos complement.

Four static configuration inputs set how the bus is read:
- a 2-bit bus-width code that selects an 8-bit bus (byte) or a 4-bit bus (nibble);
- a pair-order bit that says whether the I or the Q word arrives first;
- a reversal bit that mirrors the bit order of the active bus lanes before assembly;
- a format bit that marks the input as offset binary rather than twos complement.

A frame-start input realigns the beat counter to the start of a pair. The counter also realigns by itself when the decoded bus mode changes. The one illegal width code makes the block discard all input and raise an error flag.

Top module: `iq_bus_formatter`

## Requirements
- R1: After reset, `out_valid` is 0 and `out_i` and `out_q` are 0.
- R2: Width codes 2'b00 and 2'b01 both select byte mode: `bus_data[7:0]` is used, a sample takes 2 beats (most significant byte first) and a pair takes 4 beats. Switching between these two codes is not a mode change and does not restart the pair.
- R3: Width code 2'b10 selects nibble mode: a sample takes 4 beats from `bus_data[3:0]`, most significant nibble first, and a pair takes 8 beats.
- R4: With `cfg_q_first` = 0 the first word of a pair goes to `out_i`; with 1 it goes to `out_q`.
- R5: With `cfg_swap` = 1, each beat is bit-reversed across the active bus width before assembly. Bit k moves to bit 7-k in byte mode and to bit 3-k in nibble mode.
- R6: With `cfg_offset_bin` = 1 the input is offset binary, and each output word has its bit 15 inverted. With 0 the words pass unchanged.
- R7: Width code 2'b11 drives `mode_err` to 1 in the same cycle, discards every beat and holds `out_valid` at 0. With any other code `mode_err` is 0.
- R8: A cycle with `frame_start` = 1 restarts the pair. A beat accepted in that same cycle is the first beat of the new pair.
- R9: A change of the decoded mode (byte, nibble, invalid) restarts the pair. A beat in the cycle of the change is the first beat of the new pair.
- R10: `out_valid` is high for exactly one cycle, the cycle after the edge that accepts the last beat of a pair.
- R11: In nibble mode `bus_data[7:4]` has no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_width | input | 2 | Bus width code: 00/01 byte, 10 nibble, 11 illegal |
| cfg_q_first | input | 1 | 1: Q word arrives first in a pair |
| cfg_swap | input | 1 | 1: reverse bit order of the active bus lanes |
| cfg_offset_bin | input | 1 | 1: input words are offset binary |
| bus_data | input | 8 | Bus beat; only bits 3:0 are used in nibble mode |
| bus_valid | input | 1 | Beat on `bus_data` is valid this cycle |
| frame_start | input | 1 | Restart the pair at this cycle |
| out_valid | output | 1 | One-cycle strobe for a completed I/Q pair |
| out_i | output | 16 | I sample, twos complement |
| out_q | output | 16 | Q sample, twos complement |
| mode_err | output | 1 | Illegal width code selected |

## Verification
The bench sweeps every combination of width code, pair order, reversal and format. In each it uses words whose halves and nibbles differ, so a lane order or beat order that is wrong shows up as a scrambled output. Reversing across the full byte in nibble mode would pull the undriven upper nibble into the result. Flipping the wrong bit would corrupt the patterns 0x7FFF and 0x8000. The bench sends partial pairs before a frame start and before a mode change. A counter that fails to restart then pairs stale slices and gives the wrong words. The bench also moves between the two byte codes within one pair, where a wrong restart loses the pair entirely. It then feeds beats under the illegal code: a design that accepted them would strobe out data or misalign the next pair.

// File: rtl/iqf_pkg.sv
package iqf_pkg;

  typedef enum logic [1:0] {
    BUS_BYTE = 2'd0,
    BUS_NIB  = 2'd1,
    BUS_BAD  = 2'd2
  } bus_mode_e;

  function automatic bus_mode_e decode_width(input logic [1:0] code);
    bus_mode_e m;
    case (code)
      2'b00, 2'b01: m = BUS_BYTE;
      2'b10:        m = BUS_NIB;
      default:      m = BUS_BAD;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/iqf_lane_prep.sv
module iqf_lane_prep
  import iqf_pkg::*;
#(
  parameter int BUS_W = 8
) (
  input  bus_mode_e          mode,
  input  logic               swap,
  input  logic [BUS_W-1:0]   bus_in,
  output logic [BUS_W-1:0]   lane
);

  localparam int NIB_W = BUS_W / 2;

  logic [BUS_W-1:0] rev_full;
  logic [NIB_W-1:0] rev_nib;
  logic [NIB_W-1:0] nib_raw;

  assign nib_raw = bus_in[NIB_W-1:0];

  for (genvar k = 0; k < BUS_W; k++) begin : g_rev_full
    assign rev_full[k] = bus_in[BUS_W-1-k];
  end

  for (genvar k = 0; k < NIB_W; k++) begin : g_rev_nib
    assign rev_nib[k] = nib_raw[NIB_W-1-k];
  end

  always_comb begin
    lane = '0;
    case (mode)
      BUS_BYTE: lane = swap ? rev_full : bus_in;
      BUS_NIB:  lane[NIB_W-1:0] = swap ? rev_nib : nib_raw;
      default:  lane = '0;
    endcase
  end

endmodule

// File: rtl/iqf_word_assembler.sv
module iqf_word_assembler
  import iqf_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int BUS_W    = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  bus_mode_e           mode,
  input  logic                beat_ok,
  input  logic                restart,
  input  logic [BUS_W-1:0]    lane,
  output logic                pair_done,
  output logic [SAMPLE_W-1:0] first_word,
  output logic [SAMPLE_W-1:0] second_word
);

  localparam int NIB_W      = BUS_W / 2;
  localparam int BYTE_BEATS = SAMPLE_W / BUS_W;
  localparam int NIB_BEATS  = SAMPLE_W / NIB_W;
  localparam int CNT_W      = $clog2(2 * NIB_BEATS);

  localparam logic [CNT_W-1:0] BYTE_MID  = CNT_W'(BYTE_BEATS - 1);
  localparam logic [CNT_W-1:0] BYTE_LAST = CNT_W'(2 * BYTE_BEATS - 1);
  localparam logic [CNT_W-1:0] NIB_MID   = CNT_W'(NIB_BEATS - 1);
  localparam logic [CNT_W-1:0] NIB_LAST  = CNT_W'(2 * NIB_BEATS - 1);

  logic [CNT_W-1:0]    cnt_q, cnt_n, cnt_base;
  logic [SAMPLE_W-1:0] acc_q, acc_n;
  logic [SAMPLE_W-1:0] first_q, first_n;
  logic                acc_en, first_en;
  logic                at_mid, at_last;

  // next-state
  always_comb begin
    cnt_base  = restart ? '0 : cnt_q;
    at_mid    = (mode == BUS_NIB) ? (cnt_base == NIB_MID)  : (cnt_base == BYTE_MID);
    at_last   = (mode == BUS_NIB) ? (cnt_base == NIB_LAST) : (cnt_base == BYTE_LAST);
    acc_n     = acc_q;
    acc_en    = 1'b0;
    first_en  = 1'b0;
    pair_done = 1'b0;
    cnt_n     = cnt_base;
    if (mode == BUS_BAD) begin
      cnt_n = '0;
    end else if (beat_ok) begin
      acc_en = 1'b1;
      if (mode == BUS_NIB) begin
        acc_n = {acc_q[SAMPLE_W-NIB_W-1:0], lane[NIB_W-1:0]};
      end else begin
        acc_n = {acc_q[SAMPLE_W-BUS_W-1:0], lane};
      end
      if (at_last) begin
        pair_done = 1'b1;
        cnt_n     = '0;
      end else begin
        cnt_n = cnt_base + 1'b1;
      end
      first_en = at_mid;
    end
    first_n = acc_n;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (acc_en) begin
      acc_q <= acc_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_q <= '0;
    end else if (first_en) begin
      first_q <= first_n;
    end
  end

  assign first_word  = first_q;
  assign second_word = acc_n;

  // R2
  byte_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == BUS_BYTE && !restart) |-> (cnt_q <= BYTE_LAST));

  // R8
  restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (restart && !beat_ok) |=> (cnt_q == '0));

  // R7
  bad_mode_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == BUS_BAD) |=> (cnt_q == '0));

endmodule

// File: rtl/iqf_format_conv.sv
module iqf_format_conv #(
  parameter int SAMPLE_W = 16
) (
  input  logic                offset_bin,
  input  logic [SAMPLE_W-1:0] word_in,
  output logic [SAMPLE_W-1:0] word_out
);

  always_comb begin
    word_out               = word_in;
    word_out[SAMPLE_W-1]   = word_in[SAMPLE_W-1] ^ offset_bin;
  end

endmodule

// File: rtl/iq_bus_formatter.sv
module iq_bus_formatter
  import iqf_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int BUS_W    = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          cfg_width,
  input  logic                cfg_q_first,
  input  logic                cfg_swap,
  input  logic                cfg_offset_bin,
  input  logic [BUS_W-1:0]    bus_data,
  input  logic                bus_valid,
  input  logic                frame_start,
  output logic                out_valid,
  output logic [SAMPLE_W-1:0] out_i,
  output logic [SAMPLE_W-1:0] out_q,
  output logic                mode_err
);

  bus_mode_e           mode, prev_mode_q;
  logic                mode_chg, restart, beat_ok;
  logic [BUS_W-1:0]    lane;
  logic                pair_done;
  logic [SAMPLE_W-1:0] first_word, second_word;
  logic [SAMPLE_W-1:0] first_tc, second_tc;
  logic [SAMPLE_W-1:0] i_q, q_q, i_n, q_n;
  logic                v_q;

  assign mode     = decode_width(cfg_width);
  assign mode_chg = (mode != prev_mode_q);
  assign restart  = frame_start | mode_chg;
  assign beat_ok  = bus_valid & (mode != BUS_BAD);
  assign mode_err = (mode == BUS_BAD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_mode_q <= BUS_BYTE;
    end else begin
      prev_mode_q <= mode;
    end
  end

  iqf_lane_prep #(.BUS_W(BUS_W)) u_lane (
    .mode   (mode),
    .swap   (cfg_swap),
    .bus_in (bus_data),
    .lane   (lane)
  );

  iqf_word_assembler #(.SAMPLE_W(SAMPLE_W), .BUS_W(BUS_W)) u_asm (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode        (mode),
    .beat_ok     (beat_ok),
    .restart     (restart),
    .lane        (lane),
    .pair_done   (pair_done),
    .first_word  (first_word),
    .second_word (second_word)
  );

  iqf_format_conv #(.SAMPLE_W(SAMPLE_W)) u_conv_a (
    .offset_bin (cfg_offset_bin),
    .word_in    (first_word),
    .word_out   (first_tc)
  );

  iqf_format_conv #(.SAMPLE_W(SAMPLE_W)) u_conv_b (
    .offset_bin (cfg_offset_bin),
    .word_in    (second_word),
    .word_out   (second_tc)
  );

  // next-state
  always_comb begin
    i_n = cfg_q_first ? second_tc : first_tc;
    q_n = cfg_q_first ? first_tc  : second_tc;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q <= 1'b0;
    end else begin
      v_q <= pair_done;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      i_q <= '0;
      q_q <= '0;
    end else if (pair_done) begin
      i_q <= i_n;
      q_q <= q_n;
    end
  end

  assign out_valid = v_q & ~mode_err;
  assign out_i     = i_q;
  assign out_q     = q_q;

  // R10
  single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  // R10
  strobe_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pair_done |=> (out_valid || mode_err));

  // R7
  bad_no_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_err |-> !pair_done);

endmodule

// File: tb/iq_bus_formatter_tb.sv
`timescale 1ns/1ps
module iq_bus_formatter_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  cfg_width;
  logic        cfg_q_first, cfg_swap, cfg_offset_bin;
  logic [7:0]  bus_data;
  logic        bus_valid, frame_start;
  logic        out_valid, mode_err;
  logic [15:0] out_i, out_q;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  iq_bus_formatter u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_width(cfg_width), .cfg_q_first(cfg_q_first),
    .cfg_swap(cfg_swap), .cfg_offset_bin(cfg_offset_bin), .bus_data(bus_data),
    .bus_valid(bus_valid), .frame_start(frame_start), .out_valid(out_valid),
    .out_i(out_i), .out_q(out_q), .mode_err(mode_err)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++; errors++;
      $display("FAIL watchdog: act=%0d exp=<100000 cycles", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] rev_bits(input logic [7:0] v, input int w);
    logic [7:0] r = '0;
    for (int k = 0; k < w; k++) r[w-1-k] = v[k];
    return r;
  endfunction

  task automatic beat(input logic [7:0] d, input bit fs);
    @(negedge clk);
    bus_data = d; bus_valid = 1'b1; frame_start = fs;
  endtask

  task automatic idle();
    @(negedge clk);
    bus_valid = 1'b0; frame_start = 1'b0; bus_data = 8'h5A;
  endtask

  task automatic send_word(input logic [15:0] s, input bit fs_first);
    int w, n;
    logic [7:0] c;
    w = (cfg_width == 2'b10) ? 4 : 8;
    n = 16 / w;
    for (int k = 0; k < n; k++) begin
      c = 8'((s >> (w * (n - 1 - k))) & ((1 << w) - 1));
      if (cfg_swap) c = rev_bits(c, w);
      if (w == 4) c[7:4] = 4'(k * 5 + 9);
      beat(c, fs_first && (k == 0));
    end
  endtask

  task automatic send_pair_chk(input logic [15:0] iv, input logic [15:0] qv,
                               input bit fs, input string req);
    logic [15:0] ei, eq;
    if (cfg_q_first) begin send_word(qv, fs); send_word(iv, 1'b0); end
    else begin send_word(iv, fs); send_word(qv, 1'b0); end
    idle();
    ei = cfg_offset_bin ? (iv ^ 16'h8000) : iv;
    eq = cfg_offset_bin ? (qv ^ 16'h8000) : qv;
    chk(out_valid == 1'b1, {req, " R10 valid"}, int'(out_valid), 1);
    chk(out_i == ei, {req, " I"}, int'(out_i), int'(ei));
    chk(out_q == eq, {req, " Q"}, int'(out_q), int'(eq));
    idle();
    chk(out_valid == 1'b0, {req, " R10 one cycle"}, int'(out_valid), 0);
  endtask

  initial begin
    rst_n = 1'b0; cfg_width = 2'b00; cfg_q_first = 0; cfg_swap = 0; cfg_offset_bin = 0;
    bus_data = '0; bus_valid = 0; frame_start = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(out_valid == 0, "R1 valid", int'(out_valid), 0);
    chk(out_i == 0 && out_q == 0, "R1 data", int'({out_i, out_q}), 0);
    chk(mode_err == 0, "R7 err low", int'(mode_err), 0);
    rst_n = 1'b1;
    idle();

    // sweep R2 R3 R4 R5 R6 R11
    for (int wc = 0; wc < 3; wc++) begin
      for (int cf = 0; cf < 8; cf++) begin
        idle();
        cfg_width = 2'(wc); cfg_q_first = cf[0]; cfg_swap = cf[1]; cfg_offset_bin = cf[2];
        idle();
        send_pair_chk(16'h1234 + 16'(cf * 16'h1111), 16'hC3A5 ^ 16'(wc * 16'h0F01), 1'b1,
                      (wc == 2) ? "R3 R5 R6 R11 nibble" : "R2 R4 R5 R6 byte");
        send_pair_chk(16'h7FFF, 16'h8000, 1'b0, "R6 msb edge R4");
        send_pair_chk(16'h0001, 16'hFFFE, 1'b0, "R5 lsb edge");
        send_pair_chk(16'(cf * 16'h2469 + wc * 16'h0357), 16'(16'hE01D - cf * 16'h0B13), 1'b0,
                      "R4 R5 mixed");
      end
    end

    // R2: switch 00 -> 01 mid pair must not restart
    idle(); cfg_width = 2'b00; cfg_q_first = 0; cfg_swap = 0; cfg_offset_bin = 0;
    idle();
    send_word(16'hABCD, 1'b1);
    cfg_width = 2'b01;
    send_word(16'h4321, 1'b0);
    idle();
    chk(out_valid == 1 && out_i == 16'hABCD && out_q == 16'h4321, "R2 code 01 continues",
        int'(out_i), 16'hABCD);
    idle();

    // R8: partial pair then frame_start with beat
    cfg_width = 2'b00;
    beat(8'h11, 1'b0); beat(8'h22, 1'b0); beat(8'h33, 1'b0);
    send_pair_chk(16'h5E6F, 16'h1A2B, 1'b1, "R8 frame start");
    // R8: frame_start alone while idle
    beat(8'h99, 1'b0);
    @(negedge clk); bus_valid = 0; frame_start = 1;
    idle();
    send_pair_chk(16'h0F0F, 16'hF0F0, 1'b0, "R8 idle restart");

    // R9: partial byte pair, switch to nibble
    beat(8'h77, 1'b0);
    idle(); cfg_width = 2'b10;
    send_pair_chk(16'h369C, 16'hBEEF, 1'b0, "R9 to nibble");
    send_word(16'h1111, 1'b0);
    idle(); cfg_width = 2'b00;
    send_pair_chk(16'hCAFE, 16'h0420, 1'b0, "R9 to byte");

    // R7: illegal code
    beat(8'h3C, 1'b0);
    @(negedge clk); bus_valid = 0; cfg_width = 2'b11;
    @(negedge clk);
    chk(mode_err == 1, "R7 err high", int'(mode_err), 1);
    for (int k = 0; k < 10; k++) begin
      beat(8'(k * 37), 1'b0);
      @(posedge clk); #1;
      chk(out_valid == 0, "R7 no output", int'(out_valid), 0);
    end
    idle(); cfg_width = 2'b00;
    @(negedge clk);
    chk(mode_err == 0, "R7 err cleared", int'(mode_err), 0);
    send_pair_chk(16'h2468, 16'h9BDF, 1'b0, "R7 R9 recover");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule